// File: doc/BRIEF.md
# External Memory Bus Cycle Generator

This block sequences the external memory bus of a small 8-bit microcontroller. It runs on the oscillator clock. A machine cycle lasts twelve oscillator clocks, split into six states (S1 to S6) of two phases each. The core presents one request per machine cycle. The block then drives the address-latch strobe, the code read strobe, the data read strobe and the data write strobe. It also drives the multiplexed low port (address, then data, with an output enable) and the high port (address high byte or port-latch contents). Bytes read from the bus are returned on a capture register.

The state machine has six named states, `ST_S1` to `ST_S6`, and a phase bit. On phase 2 of each state it moves to the next state: ST_S1→ST_S2→ST_S3→ST_S4→ST_S5→ST_S6→ST_S1. The request kind, address, write data, port latch and ALE-disable bit are loaded on the clock edge that ends S6 phase 2, and also on every clock while reset is held. They stay fixed for the whole of the next machine cycle.

An external code fetch makes two fetches per machine cycle, from the address and from the address plus one. A data access drops the second ALE pulse and both code strobes, and asserts its read or write strobe in the second half of the cycle.

Top module: `xbus_cycle_gen`

## Requirements
- R1: A machine cycle is 12 clocks, counted 0 to 11 from S1 phase 1. For an external code fetch, `ale` is high for exactly one clock at count 0 and at count 6, and low on all other counts.
- R2: `req_kind` is encoded as 0 internal fetch, 1 external code fetch, 2 read with 16-bit pointer, 3 write with 16-bit pointer, 4 read with 8-bit pointer, 5 write with 8-bit pointer. Codes 6 and 7 behave as 0. All request inputs are sampled at the edge that ends count 11 and apply to the whole following cycle.
- R3: During an external code fetch, `psen_n` is low on counts 2–5 and 8–11. The low port drives the low byte of `req_addr` on counts 0–1 and the low byte of `req_addr`+1 on counts 6–7, and it is released at all other counts. The high port carries the high byte of `req_addr` on counts 0–5 and the high byte of `req_addr`+1 on counts 6–11, with a carry from the low byte.
- R4: During a data access (kinds 2 to 5), `ale` pulses only at count 0, and `psen_n` stays high for the whole cycle.
- R5: `rd_n` is low on counts 6–11 of a read cycle, and `wr_n` is low on counts 6–11 of a write cycle. Neither is low in any other cycle, and `ale` is low while either is low.
- R6: During a data access, the low port drives the low address byte on counts 0–1. On counts 2–11 it drives `req_wdata` for a write and is released for a read.
- R7: For a read access, `lo_in` is captured at the end of count 11. For an external code fetch, `lo_in` is captured at the end of count 5 and at the end of count 11. Each capture shows on `rdata` with `rdata_vld` high for exactly the next clock. `rdata_vld` is low at all other times.
- R8: For an external code fetch and for 16-bit pointer accesses, `hi_strong` is 1 and the high port carries address bits. For 8-bit pointer accesses and internal fetches, `hi_strong` is 0 and `hi_out` equals `p2_sfr`.
- R9: An internal fetch leaves `psen_n`, `rd_n` and `wr_n` high and the low port released. It pulses `ale` at counts 0 and 6 when `ale_off` is 0, and leaves `ale` low for the whole cycle when `ale_off` is 1.
- R10: `ale_off` has no effect on external code fetches or data accesses.
- R11: `rst` is synchronous and active high. While it is high, `ale` is 0, all strobes are 1 and `lo_oe` is 0. From the first clock of reset on, `rdata_vld` is 0. After `rst` is released, the block begins at count 0 (S1 phase 1) with the request presented during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_kind | input | 3 | Request kind for the next machine cycle (R2 encoding) |
| req_addr | input | ADDR_W | Code or data address |
| req_wdata | input | DATA_W | Write data for data write cycles |
| p2_sfr | input | ADDR_W-DATA_W | Port-2 latch contents |
| ale_off | input | 1 | ALE-disable control bit |
| lo_in | input | DATA_W | Value read from the low port pins |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | DATA_W | Low port drive value |
| lo_oe | output | 1 | Low port output enable |
| hi_out | output | ADDR_W-DATA_W | High port drive value |
| hi_strong | output | 1 | High port carries address (strong drive of ones) |
| rdata | output | DATA_W | Last captured byte |
| rdata_vld | output | 1 | One-clock pulse marking a new capture |

## Verification
A wrong state or phase register moves the `ale` pulses away from counts 0 and 6, or changes the spacing of the `psen_n` window. This shows at the ports within one machine cycle. A request latched at the wrong edge, or decoded as the wrong kind, gives the wrong strobe set, the wrong `hi_out` source or the wrong `lo_oe` pattern on the very next cycle. An early or late capture enable shows up as a misplaced `rdata_vld` pulse or a wrong `rdata` byte. The bench changes `lo_in` between the two halves of the cycle to expose this.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        RQ_INT   = 3'd0,
        RQ_XCODE = 3'd1,
        RQ_RD16  = 3'd2,
        RQ_WR16  = 3'd3,
        RQ_RD8   = 3'd4,
        RQ_WR8   = 3'd5
    } req_kind_t;

    typedef enum logic [2:0] {
        ST_S1 = 3'd0,
        ST_S2 = 3'd1,
        ST_S3 = 3'd2,
        ST_S4 = 3'd3,
        ST_S5 = 3'd4,
        ST_S6 = 3'd5
    } mstate_t;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [HI_W-1:0]   p2_sfr,
    input  logic              ale_off,
    output mstate_t           st,
    output logic              ph,
    output req_kind_t         kq,
    output logic [ADDR_W-1:0] aq,
    output logic [DATA_W-1:0] wq,
    output logic [HI_W-1:0]   pq,
    output logic              dq
);

    mstate_t st_nxt;
    logic    last;

    assign last = (st == ST_S6) && ph;

    always_comb begin
        unique case (st)
            ST_S1:   st_nxt = ST_S2;
            ST_S2:   st_nxt = ST_S3;
            ST_S3:   st_nxt = ST_S4;
            ST_S4:   st_nxt = ST_S5;
            ST_S5:   st_nxt = ST_S6;
            ST_S6:   st_nxt = ST_S1;
            default: st_nxt = ST_S1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_S1;
            ph <= 1'b0;
        end else begin
            ph <= ~ph;
            if (ph) st <= st_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || last) begin
            kq <= (req_kind > 3'd5) ? RQ_INT : req_kind_t'(req_kind);
            aq <= req_addr;
            wq <= req_wdata;
            pq <= p2_sfr;
            dq <= ale_off;
        end
    end

    AST_CYCLE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_S6 && ph) |=> (st == ST_S1 && !ph)); // R1

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ph |=> $stable(st)); // R1

endmodule

// File: rtl/xbus_strobes.sv
module xbus_strobes
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mstate_t           st,
    input  logic              ph,
    input  req_kind_t         kq,
    input  logic [ADDR_W-1:0] aq,
    input  logic [DATA_W-1:0] wq,
    input  logic [HI_W-1:0]   pq,
    input  logic              dq,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              hi_strong,
    output logic              cap_en
);

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic              is_rd, is_wr, wide, late, ale_slot;
    logic [ADDR_W-1:0] fa;

    always_comb begin
        is_rd    = (kq == RQ_RD16) || (kq == RQ_RD8);
        is_wr    = (kq == RQ_WR16) || (kq == RQ_WR8);
        wide     = (kq == RQ_RD16) || (kq == RQ_WR16);
        late     = (st >= ST_S4);
        fa       = late ? aq + ONE : aq;
        ale_slot = !ph && ((st == ST_S1) || (st == ST_S4));

        ale       = 1'b0;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        lo_oe     = 1'b0;
        lo_out    = '0;
        hi_out    = pq;
        hi_strong = 1'b0;
        cap_en    = 1'b0;

        if (!rst) begin
            unique case (kq)
                RQ_XCODE: begin
                    ale       = ale_slot;
                    psen_n    = (st == ST_S1) || (st == ST_S4);
                    lo_oe     = (st == ST_S1) || (st == ST_S4);
                    lo_out    = lo_oe ? fa[DATA_W-1:0] : '0;
                    hi_out    = fa[ADDR_W-1:DATA_W];
                    hi_strong = 1'b1;
                    cap_en    = ph && ((st == ST_S3) || (st == ST_S6));
                end
                RQ_RD16, RQ_WR16, RQ_RD8, RQ_WR8: begin
                    ale    = !ph && (st == ST_S1);
                    rd_n   = !(is_rd && late);
                    wr_n   = !(is_wr && late);
                    lo_oe  = (st == ST_S1) || is_wr;
                    lo_out = (st == ST_S1) ? aq[DATA_W-1:0] : (is_wr ? wq : '0);
                    if (wide) begin
                        hi_out    = aq[ADDR_W-1:DATA_W];
                        hi_strong = 1'b1;
                    end
                    cap_en = is_rd && ph && (st == ST_S6);
                end
                default: begin
                    ale = ale_slot && !dq;
                end
            endcase
        end
    end

    AST_ALE_NARROW: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R1

    AST_NO_PSEN_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> psen_n); // R4

    AST_STROBE_QUIET_ALE: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !ale); // R5

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !lo_oe); // R6

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R5

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] lo_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata_vld <= cap_en;
            if (cap_en) rdata <= lo_in;
        end
    end

    AST_RESET_NO_VLD: assert property (@(posedge clk)
        rst |=> !rdata_vld); // R11

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rdata_vld |=> !rdata_vld); // R7

endmodule

// File: rtl/xbus_cycle_gen.sv
module xbus_cycle_gen
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [ADDR_W-DATA_W-1:0] p2_sfr,
    input  logic                     ale_off,
    input  logic [DATA_W-1:0]        lo_in,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        lo_out,
    output logic                     lo_oe,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic                     hi_strong,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_vld
);

    localparam int HI_W = ADDR_W - DATA_W;

    mstate_t           st;
    logic              ph;
    req_kind_t         kq;
    logic [ADDR_W-1:0] aq;
    logic [DATA_W-1:0] wq;
    logic [HI_W-1:0]   pq;
    logic              dq;
    logic              cap_en;

    xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .p2_sfr    (p2_sfr),
        .ale_off   (ale_off),
        .st        (st),
        .ph        (ph),
        .kq        (kq),
        .aq        (aq),
        .wq        (wq),
        .pq        (pq),
        .dq        (dq)
    );

    xbus_strobes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strb (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .ph        (ph),
        .kq        (kq),
        .aq        (aq),
        .wq        (wq),
        .pq        (pq),
        .dq        (dq),
        .ale       (ale),
        .psen_n    (psen_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .lo_out    (lo_out),
        .lo_oe     (lo_oe),
        .hi_out    (hi_out),
        .hi_strong (hi_strong),
        .cap_en    (cap_en)
    );

    xbus_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .lo_in     (lo_in),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

endmodule

// File: tb/sim_xbus_cycle_gen.sv
module sim_xbus_cycle_gen;

    localparam int PER = 10;

    typedef struct packed {
        logic [2:0]  kind;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  p2;
        logic        aoff;
        logic [7:0]  din;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 16'h1234, 8'h00, 8'hA5, 1'b0, 8'h3C},
        '{3'd1, 16'h12FF, 8'h00, 8'hA5, 1'b1, 8'h5A},
        '{3'd2, 16'hBEEF, 8'h00, 8'h11, 1'b0, 8'hC3},
        '{3'd3, 16'h4321, 8'h9E, 8'h11, 1'b1, 8'h00},
        '{3'd4, 16'h0077, 8'h00, 8'h6B, 1'b1, 8'h81},
        '{3'd5, 16'h00F0, 8'h42, 8'hD2, 1'b0, 8'h00},
        '{3'd0, 16'h0000, 8'h00, 8'h33, 1'b0, 8'h00},
        '{3'd0, 16'h0000, 8'h00, 8'h44, 1'b1, 8'h00},
        '{3'd7, 16'h0000, 8'h00, 8'h55, 1'b1, 8'h00},
        '{3'd1, 16'hFFFF, 8'h00, 8'h55, 1'b0, 8'hE7}
    };
    localparam vec_t DIR  = '{3'd1, 16'h0400, 8'h00, 8'h77, 1'b1, 8'h96};
    localparam vec_t IDLE = '{3'd0, 16'h0000, 8'h00, 8'h00, 1'b1, 8'h00};

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata;
    logic [7:0]  p2_sfr;
    logic        ale_off;
    logic [7:0]  lo_in;
    logic        ale, psen_n, rd_n, wr_n, lo_oe, hi_strong, rdata_vld;
    logic [7:0]  lo_out, hi_out, rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic       pend_vld = 1'b0;
    logic [7:0] pend_val = 8'h00;

    always #(PER/2) clk = ~clk;

    xbus_cycle_gen u0 (
        .clk(clk), .rst(rst), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .p2_sfr(p2_sfr), .ale_off(ale_off), .lo_in(lo_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out),
        .lo_oe(lo_oe), .hi_out(hi_out), .hi_strong(hi_strong), .rdata(rdata),
        .rdata_vld(rdata_vld)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        req_kind  = v.kind;
        req_addr  = v.addr;
        req_wdata = v.wd;
        p2_sfr    = v.p2;
        ale_off   = v.aoff;
    endtask

    task automatic run_cycle(input vec_t v, input vec_t nx);
        logic code, rd, wr, data, wide, intl;
        logic [15:0] a1;
        string atag;
        code = (v.kind == 3'd1);
        rd   = (v.kind == 3'd2) || (v.kind == 3'd4);
        wr   = (v.kind == 3'd3) || (v.kind == 3'd5);
        data = rd || wr;
        wide = (v.kind == 3'd2) || (v.kind == 3'd3);
        intl = !code && !data;
        a1   = v.addr + 16'd1;
        atag = intl ? "R9" : (v.aoff ? "R10" : (code ? "R1" : "R4"));
        for (int i = 0; i < 12; i++) begin
            logic e_ale, e_psen, e_oe, e_vld;
            logic [7:0] e_lo, e_hi, e_rd;
            lo_in = (i < 6) ? v.din : ~v.din;
            if (i == 0)      e_ale = code || data || !v.aoff;
            else if (i == 6) e_ale = code || (intl && !v.aoff);
            else             e_ale = 1'b0;
            e_psen = !(code && ((i >= 2 && i <= 5) || i >= 8));
            if (code)      e_oe = (i == 0 || i == 1 || i == 6 || i == 7);
            else if (data) e_oe = (i < 2) || wr;
            else           e_oe = 1'b0;
            if (code)      e_lo = (i < 6) ? v.addr[7:0] : a1[7:0];
            else           e_lo = (i < 2) ? v.addr[7:0] : v.wd;
            if (code)      e_hi = (i < 6) ? v.addr[15:8] : a1[15:8];
            else if (wide) e_hi = v.addr[15:8];
            else           e_hi = v.p2;
            if (i == 0)      begin e_vld = pend_vld; e_rd = pend_val; end
            else if (i == 6) begin e_vld = code;     e_rd = v.din;    end
            else             begin e_vld = 1'b0;     e_rd = 8'h00;    end
            chk(atag, "ale", {15'd0, ale}, {15'd0, e_ale});
            chk(data ? "R4" : "R3", "psen_n", {15'd0, psen_n}, {15'd0, e_psen});
            chk("R5", "rd_n", {15'd0, rd_n}, {15'd0, !(rd && i >= 6)});
            chk("R5", "wr_n", {15'd0, wr_n}, {15'd0, !(wr && i >= 6)});
            chk(code ? "R3" : (data ? "R6" : "R9"), "lo_oe", {15'd0, lo_oe}, {15'd0, e_oe});
            if (e_oe) chk(code ? "R3" : "R6", "lo_out", {8'd0, lo_out}, {8'd0, e_lo});
            chk("R8", "hi_out", {8'd0, hi_out}, {8'd0, e_hi});
            chk("R8", "hi_strong", {15'd0, hi_strong}, {15'd0, code || wide});
            chk("R7", "rdata_vld", {15'd0, rdata_vld}, {15'd0, e_vld});
            if (e_vld) chk("R7", "rdata", {8'd0, rdata}, {8'd0, e_rd});
            if (i == 11) apply(nx);
            @(negedge clk); #1;
        end
        pend_vld = code || rd;
        pend_val = ~v.din;
    endtask

    initial begin
        #(PER * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst   = 1'b1;
        lo_in = 8'h00;
        apply(VEC[0]);
        repeat (3) @(negedge clk);
        #1;
        // R11: outputs quiet during reset
        chk("R11", "ale", {15'd0, ale}, 16'd0);
        chk("R11", "psen_n", {15'd0, psen_n}, 16'd1);
        chk("R11", "rd_n/wr_n", {14'd0, rd_n, wr_n}, 16'd3);
        chk("R11", "lo_oe", {15'd0, lo_oe}, 16'd0);
        chk("R11", "rdata_vld", {15'd0, rdata_vld}, 16'd0);
        rst = 1'b0;
        #1;
        // Table walk: R1..R10 across all request kinds (R2 includes code 7)
        for (int k = 0; k < NV; k++)
            run_cycle(VEC[k], (k == NV - 1) ? DIR : VEC[k + 1]);
        // R11: reset asserted where ALE and a capture pulse are due
        rst = 1'b1;
        #1;
        chk("R11", "ale in reset", {15'd0, ale}, 16'd0);
        chk("R11", "psen_n in reset", {15'd0, psen_n}, 16'd1);
        chk("R11", "lo_oe in reset", {15'd0, lo_oe}, 16'd0);
        @(negedge clk); #1;
        chk("R11", "rdata_vld in reset", {15'd0, rdata_vld}, 16'd0);
        apply(DIR);
        @(negedge clk); #1;
        rst = 1'b0;
        #1;
        pend_vld = 1'b0;
        // R11: restart at S1 phase 1 with the request held in reset
        run_cycle(DIR, IDLE);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule